// File: doc/BRIEF.md
# Prioritised Interrupt Selector with Non-Maskable Level

This block decides which interrupt a small core takes, and when it takes it. Each request line has a configured kind and a priority level. The block keeps a pending register for the lines that latch. It combines that register with the enable mask and returns the highest level that is pending. It then compares that level with the core's current interrupt level and exception-mode flag. When an interrupt is taken, it raises a one-cycle take strobe, reports the taken level and vector index, and registers the new status fields for the core to load.

Levels 1 to `N_MASK_LEVELS` are maskable. The level one above them (7 by default) is the non-maskable level. Only lines of the non-maskable kind reach that level. Such a line is taken whatever the enable mask, current level and exception mode hold, and its pending bit clears on the take. Software can set pending bits of software-kind lines. It can clear pending bits of software-kind and edge-kind lines. Instruction execution, vector relocation and the exception pipeline are outside this block.

Top module: `irq_arbiter`

## Requirements
- R1: `pend_level_o` is the highest level that has a line both pending and enabled, or 0 when there is none. Line i's level sits in `line_level_i[3i+2:3i]`. A maskable line counts only at levels 1..6, so a maskable line configured at level 7 (or 0) never counts.
- R2: A maskable level L is taken only when L exceeds the effective current level. The effective current level is the larger of `ps_intlevel_i` and, when `ps_excm_i` is 1, the value 3.
- R3: A line whose kind field `line_kind_i[2i+1:2i]` is 3 (non-maskable) latches on a rising edge at level 7. That level is taken even when the enable bit is 0, `ps_intlevel_i` is 7 and `ps_excm_i` is 1.
- R4: In the cycle that level 7 is taken, every pending bit of kind 3 clears, so `pend_level_o` falls in the next cycle.
- R5: `take_o` is high for one cycle at a time. It is always low in the cycle that follows a take.
- R6: During a take above level 1, `vec_idx_o` equals the taken level. In the next cycle `stat_upd_o` is 1, `stat_intlevel_o` holds the taken level and `stat_excm_o` is 1.
- R7: During a level-1 take, `vec_idx_o` is 0. In the next cycle `cause_vld_o` is 1, `cause_o` is 4, `stat_excm_o` is 1 and `stat_intlevel_o` holds the current level unchanged.
- R8: A line of kind 0 (level) is pending exactly while `irq_i` is high. A software clear write has no effect on it.
- R9: A line of kind 1 (edge) becomes pending on a rising edge of `irq_i` and stays pending until a software clear write. When a rising edge and a clear reach the same bit in the same cycle, the edge wins.
- R10: A software set write makes a line of kind 2 (software) pending, and a software clear write clears it. A set write to a line of any other kind has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Raw request lines |
| line_kind_i | input | 64 | Kind per line: 0 level, 1 edge, 2 software, 3 non-maskable |
| line_level_i | input | 96 | Priority level per line, 3 bits each |
| int_enable_i | input | 32 | Enable mask |
| ps_intlevel_i | input | 3 | Current interrupt level of the core |
| ps_excm_i | input | 1 | Exception mode of the core |
| sw_set_i | input | 1 | Software set write strobe |
| sw_clr_i | input | 1 | Software clear write strobe |
| sw_data_i | input | 32 | Bit mask for set/clear writes |
| pend_level_o | output | 3 | Highest pending enabled level |
| take_o | output | 1 | Interrupt taken this cycle |
| take_level_o | output | 3 | Level being taken |
| vec_idx_o | output | 3 | Vector index (0 for level 1) |
| stat_upd_o | output | 1 | Status update valid |
| stat_intlevel_o | output | 3 | New interrupt level |
| stat_excm_o | output | 1 | New exception mode |
| cause_vld_o | output | 1 | Level-1 cause valid |
| cause_o | output | 6 | Level-1 interrupt cause code |

## Verification
A table of level-kind request patterns is applied under different enable masks, current levels and exception-mode values. It separates the highest-level pick from the masking by enable, by current level and by exception mode. It also covers a maskable line parked above the maskable range. Directed sequences then cover state and ordering:
- a non-maskable request against a full mask, and its clearing on the take;
- an edge that arrives together with a clear;
- set writes to lines of the wrong kind;
- the status and cause outputs one cycle after takes at level 1 and above level 1.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    KIND_LEVEL = 2'd0,
    KIND_EDGE  = 2'd1,
    KIND_SOFT  = 2'd2,
    KIND_NMI   = 2'd3
  } line_kind_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N_LINES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] is_lvl_i,
  input  logic [N_LINES-1:0] is_edge_i,
  input  logic [N_LINES-1:0] is_soft_i,
  input  logic [N_LINES-1:0] is_nmi_i,
  input  logic               sw_set_i,
  input  logic               sw_clr_i,
  input  logic [N_LINES-1:0] sw_data_i,
  input  logic               nmi_taken_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] irq_q, pend_q, rise, set_v, clr_v;

  assign rise  = irq_i & ~irq_q;
  assign set_v = ((is_edge_i | is_nmi_i) & rise)
               | (is_soft_i & {N_LINES{sw_set_i}} & sw_data_i);
  assign clr_v = ((is_edge_i | is_soft_i) & {N_LINES{sw_clr_i}} & sw_data_i)
               | (is_nmi_i & {N_LINES{nmi_taken_i}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      // set after clear: a fresh edge beats a clear on the same bit
      pend_q <= ((pend_q & ~clr_v) | set_v) & ~is_lvl_i;
    end
  end

  assign pend_o = (is_lvl_i & irq_i) | pend_q;
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel #(
  parameter int N_LINES       = 32,
  parameter int N_MASK_LEVELS = 6,
  parameter bit HAVE_NMI      = 1'b1,
  parameter int LVL_W         = 3
) (
  input  logic [N_LINES-1:0]       pend_i,
  input  logic [N_LINES-1:0]       enable_i,
  input  logic [N_LINES-1:0]       is_nmi_i,
  input  logic [N_LINES*LVL_W-1:0] line_level_i,
  output logic [LVL_W-1:0]         pend_level_o
);
  localparam int NMI_LVL = N_MASK_LEVELS + 1;

  logic [N_LINES-1:0] nmi_ok, act;
  logic [NMI_LVL:0]   hit;

  assign nmi_ok = HAVE_NMI ? is_nmi_i : '0;
  assign act    = pend_i & (enable_i | nmi_ok);
  assign hit[0] = 1'b0;

  for (genvar l = 1; l <= NMI_LVL; l++) begin : g_lvl
    logic [N_LINES-1:0] member;
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
      if (l == NMI_LVL) begin : g_nmi
        assign member[i] = nmi_ok[i];
      end else begin : g_mask
        assign member[i] = ~is_nmi_i[i] &&
                           (line_level_i[i*LVL_W +: LVL_W] == LVL_W'(l));
      end
    end
    assign hit[l] = |(act & member);
  end

  always_comb begin
    pend_level_o = '0;
    for (int l = 1; l <= NMI_LVL; l++) begin
      if (hit[l]) pend_level_o = LVL_W'(l);
    end
  end
endmodule

// File: rtl/irq_take_ctl.sv
module irq_take_ctl #(
  parameter int N_MASK_LEVELS = 6,
  parameter bit HAVE_NMI      = 1'b1,
  parameter int EXCM_LEVEL    = 3,
  parameter int LVL_W         = 3,
  parameter int CAUSE_W       = 6,
  parameter int L1_CAUSE      = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LVL_W-1:0]   pend_level_i,
  input  logic [LVL_W-1:0]   ps_intlevel_i,
  input  logic               ps_excm_i,
  output logic               take_o,
  output logic [LVL_W-1:0]   take_level_o,
  output logic [LVL_W-1:0]   vec_idx_o,
  output logic               nmi_take_o,
  output logic               stat_upd_o,
  output logic [LVL_W-1:0]   stat_intlevel_o,
  output logic               stat_excm_o,
  output logic               cause_vld_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam logic [LVL_W-1:0] NMI_V  = LVL_W'(N_MASK_LEVELS + 1);
  localparam logic [LVL_W-1:0] CAP_V  = LVL_W'(N_MASK_LEVELS);
  localparam logic [LVL_W-1:0] EXCM_V = LVL_W'(EXCM_LEVEL);
  localparam logic [LVL_W-1:0] MAXM_V = LVL_W'(N_MASK_LEVELS);

  logic [LVL_W-1:0] cur_lvl, cap_lvl;
  logic             is_nmi_lvl, can_take, take_q;

  always_comb begin
    cur_lvl = ps_intlevel_i;
    if (ps_excm_i && EXCM_V > cur_lvl) cur_lvl = EXCM_V;
    cap_lvl = (cur_lvl > CAP_V) ? CAP_V : cur_lvl;
  end

  assign is_nmi_lvl = HAVE_NMI && (pend_level_i == NMI_V);
  assign can_take   = is_nmi_lvl ||
                      (pend_level_i != '0 && pend_level_i > cap_lvl &&
                       pend_level_i <= MAXM_V);
  // one idle cycle after a take lets the core load the new status
  assign take_o       = can_take && !take_q;
  assign take_level_o = pend_level_i;
  assign vec_idx_o    = (pend_level_i > LVL_W'(1)) ? pend_level_i : '0;
  assign nmi_take_o   = take_o && is_nmi_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q          <= 1'b0;
      stat_upd_o      <= 1'b0;
      stat_intlevel_o <= '0;
      stat_excm_o     <= 1'b0;
      cause_vld_o     <= 1'b0;
    end else begin
      take_q      <= take_o;
      stat_upd_o  <= take_o;
      cause_vld_o <= take_o && (pend_level_i == LVL_W'(1));
      if (take_o) begin
        stat_intlevel_o <= (pend_level_i > LVL_W'(1)) ? pend_level_i : ps_intlevel_i;
        stat_excm_o     <= 1'b1;
      end
    end
  end

  assign cause_o = cause_vld_o ? CAUSE_W'(L1_CAUSE) : '0;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_LINES       = 32,
  parameter int N_MASK_LEVELS = 6,
  parameter bit HAVE_NMI      = 1'b1,
  parameter int EXCM_LEVEL    = 3,
  parameter int CAUSE_W       = 6,
  parameter int L1_CAUSE      = 4,
  localparam int LVL_W        = $clog2(N_MASK_LEVELS + 2)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_LINES-1:0]       irq_i,
  input  logic [2*N_LINES-1:0]     line_kind_i,
  input  logic [N_LINES*LVL_W-1:0] line_level_i,
  input  logic [N_LINES-1:0]       int_enable_i,
  input  logic [LVL_W-1:0]         ps_intlevel_i,
  input  logic                     ps_excm_i,
  input  logic                     sw_set_i,
  input  logic                     sw_clr_i,
  input  logic [N_LINES-1:0]       sw_data_i,
  output logic [LVL_W-1:0]         pend_level_o,
  output logic                     take_o,
  output logic [LVL_W-1:0]         take_level_o,
  output logic [LVL_W-1:0]         vec_idx_o,
  output logic                     stat_upd_o,
  output logic [LVL_W-1:0]         stat_intlevel_o,
  output logic                     stat_excm_o,
  output logic                     cause_vld_o,
  output logic [CAUSE_W-1:0]       cause_o
);
  import irq_arb_pkg::*;

  logic [N_LINES-1:0] is_lvl, is_edge, is_soft, is_nmi, pend;
  logic               nmi_take;

  for (genvar i = 0; i < N_LINES; i++) begin : g_kind
    line_kind_e k;
    assign k          = line_kind_e'(line_kind_i[2*i +: 2]);
    assign is_lvl[i]  = (k == KIND_LEVEL);
    assign is_edge[i] = (k == KIND_EDGE);
    assign is_soft[i] = (k == KIND_SOFT);
    assign is_nmi[i]  = (k == KIND_NMI);
  end

  irq_pend_reg #(.N_LINES(N_LINES)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .is_lvl_i    (is_lvl),
    .is_edge_i   (is_edge),
    .is_soft_i   (is_soft),
    .is_nmi_i    (is_nmi),
    .sw_set_i    (sw_set_i),
    .sw_clr_i    (sw_clr_i),
    .sw_data_i   (sw_data_i),
    .nmi_taken_i (nmi_take),
    .pend_o      (pend)
  );

  irq_level_sel #(
    .N_LINES(N_LINES), .N_MASK_LEVELS(N_MASK_LEVELS),
    .HAVE_NMI(HAVE_NMI), .LVL_W(LVL_W)
  ) u_sel (
    .pend_i       (pend),
    .enable_i     (int_enable_i),
    .is_nmi_i     (is_nmi),
    .line_level_i (line_level_i),
    .pend_level_o (pend_level_o)
  );

  irq_take_ctl #(
    .N_MASK_LEVELS(N_MASK_LEVELS), .HAVE_NMI(HAVE_NMI), .EXCM_LEVEL(EXCM_LEVEL),
    .LVL_W(LVL_W), .CAUSE_W(CAUSE_W), .L1_CAUSE(L1_CAUSE)
  ) u_take (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .pend_level_i    (pend_level_o),
    .ps_intlevel_i   (ps_intlevel_i),
    .ps_excm_i       (ps_excm_i),
    .take_o          (take_o),
    .take_level_o    (take_level_o),
    .vec_idx_o       (vec_idx_o),
    .nmi_take_o      (nmi_take),
    .stat_upd_o      (stat_upd_o),
    .stat_intlevel_o (stat_intlevel_o),
    .stat_excm_o     (stat_excm_o),
    .cause_vld_o     (cause_vld_o),
    .cause_o         (cause_o)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N_MASK_LEVELS = 6,
  parameter int EXCM_LEVEL    = 3,
  parameter int LVL_W         = 3,
  parameter int CAUSE_W       = 6,
  parameter int L1_CAUSE      = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [LVL_W-1:0]   ps_intlevel_i,
  input logic               ps_excm_i,
  input logic [LVL_W-1:0]   pend_level_o,
  input logic               take_o,
  input logic [LVL_W-1:0]   take_level_o,
  input logic               stat_upd_o,
  input logic [LVL_W-1:0]   stat_intlevel_o,
  input logic               stat_excm_o,
  input logic               cause_vld_o,
  input logic [CAUSE_W-1:0] cause_o
);
  localparam logic [LVL_W-1:0] NMI_V  = LVL_W'(N_MASK_LEVELS + 1);
  localparam logic [LVL_W-1:0] EXCM_V = LVL_W'(EXCM_LEVEL);

  logic [LVL_W-1:0] cur;
  assign cur = (ps_excm_i && EXCM_V > ps_intlevel_i) ? EXCM_V : ps_intlevel_i;

  a_r5_single_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  a_r3_nmi_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_level_o == NMI_V) |-> (take_o || stat_upd_o));

  a_r2_mask_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && take_level_o != NMI_V) |->
      (take_level_o > cur && take_level_o <= LVL_W'(N_MASK_LEVELS)));

  a_r6_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && take_level_o > LVL_W'(1)) |=>
      (stat_upd_o && stat_excm_o && stat_intlevel_o == $past(take_level_o)));

  a_r7_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && take_level_o == LVL_W'(1)) |=>
      (cause_vld_o && cause_o == CAUSE_W'(L1_CAUSE) && stat_excm_o));
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .N_MASK_LEVELS(N_MASK_LEVELS), .EXCM_LEVEL(EXCM_LEVEL),
  .LVL_W(LVL_W), .CAUSE_W(CAUSE_W), .L1_CAUSE(L1_CAUSE)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ps_intlevel_i   (ps_intlevel_i),
  .ps_excm_i       (ps_excm_i),
  .pend_level_o    (pend_level_o),
  .take_o          (take_o),
  .take_level_o    (take_level_o),
  .stat_upd_o      (stat_upd_o),
  .stat_intlevel_o (stat_intlevel_o),
  .stat_excm_o     (stat_excm_o),
  .cause_vld_o     (cause_vld_o),
  .cause_o         (cause_o)
);

// File: tb/irq_arbiter_tb_top.sv
module irq_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  typedef struct packed {
    logic [31:0] irq;
    logic [31:0] en;
    logic [2:0]  il;
    logic        excm;
    logic [2:0]  pend;
    logic        take;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{32'h0000_0001, 32'hFFFF_FFFF, 3'd0, 1'b0, 3'd1, 1'b1},
    '{32'h0000_0020, 32'hFFFF_FFFF, 3'd0, 1'b0, 3'd6, 1'b1},
    '{32'h0000_000A, 32'hFFFF_FFFF, 3'd0, 1'b0, 3'd4, 1'b1},
    '{32'h0000_0008, 32'h0000_0000, 3'd0, 1'b0, 3'd0, 1'b0},
    '{32'h0000_0008, 32'hFFFF_FFFF, 3'd4, 1'b0, 3'd4, 1'b0},
    '{32'h0000_0008, 32'hFFFF_FFFF, 3'd3, 1'b0, 3'd4, 1'b1},
    '{32'h0000_0004, 32'hFFFF_FFFF, 3'd0, 1'b1, 3'd3, 1'b0},
    '{32'h0000_0008, 32'hFFFF_FFFF, 3'd0, 1'b1, 3'd4, 1'b1},
    '{32'h8000_0000, 32'hFFFF_FFFF, 3'd0, 1'b0, 3'd0, 1'b0},
    '{32'h0000_0410, 32'h0000_0400, 3'd0, 1'b0, 3'd5, 1'b1},
    '{32'h0000_0021, 32'h0000_0001, 3'd0, 1'b0, 3'd1, 1'b1}
  };

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0]  irq = '0, en = '0, sw_data = '0;
  logic [2*N-1:0] kind_cfg;
  logic [3*N-1:0] lvl_cfg;
  logic [2:0]    ps_il = '0;
  logic          ps_excm = 1'b0, sw_set = 1'b0, sw_clr = 1'b0;
  logic [2:0]    pend_level, take_level, vec_idx, stat_il;
  logic          take, stat_upd, stat_excm, cause_vld;
  logic [5:0]    cause;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .line_kind_i(kind_cfg),
    .line_level_i(lvl_cfg), .int_enable_i(en), .ps_intlevel_i(ps_il),
    .ps_excm_i(ps_excm), .sw_set_i(sw_set), .sw_clr_i(sw_clr), .sw_data_i(sw_data),
    .pend_level_o(pend_level), .take_o(take), .take_level_o(take_level),
    .vec_idx_o(vec_idx), .stat_upd_o(stat_upd), .stat_intlevel_o(stat_il),
    .stat_excm_o(stat_excm), .cause_vld_o(cause_vld), .cause_o(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sw_write(input bit set, input bit clr, input int bitn);
    @(negedge clk);
    sw_set = set; sw_clr = clr; sw_data = '0; sw_data[bitn] = 1'b1;
    @(negedge clk);
    sw_set = 1'b0; sw_clr = 1'b0; sw_data = '0;
    #1;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      if (i < 24) begin kind_cfg[2*i +: 2] = 2'd0; lvl_cfg[3*i +: 3] = 3'((i % 6) + 1); end
      else if (i < 28) begin kind_cfg[2*i +: 2] = 2'd1; lvl_cfg[3*i +: 3] = 3'(i - 22); end
      else if (i == 28) begin kind_cfg[2*i +: 2] = 2'd2; lvl_cfg[3*i +: 3] = 3'd1; end
      else if (i == 29) begin kind_cfg[2*i +: 2] = 2'd2; lvl_cfg[3*i +: 3] = 3'd3; end
      else if (i == 30) begin kind_cfg[2*i +: 2] = 2'd3; lvl_cfg[3*i +: 3] = 3'd0; end
      else begin kind_cfg[2*i +: 2] = 2'd0; lvl_cfg[3*i +: 3] = 3'd7; end
    end
    repeat (3) @(negedge clk);
    #1;
    chk("reset pend_level", int'(pend_level), 0);
    chk("reset stat_upd", int'(stat_upd), 0);
    chk("reset cause_vld", int'(cause_vld), 0);
    rst_ni = 1'b1;

    // R1 R2 selection table
    for (int v = 0; v < 11; v++) begin
      @(negedge clk);
      irq = VECS[v].irq; en = VECS[v].en; ps_il = VECS[v].il; ps_excm = VECS[v].excm;
      #1;
      chk($sformatf("R1 pend_level vec%0d", v), int'(pend_level), int'(VECS[v].pend));
      chk($sformatf("R2 take vec%0d", v), int'(take), int'(VECS[v].take));
      if (VECS[v].take) begin
        chk($sformatf("R6 vec_idx vec%0d", v), int'(vec_idx),
            VECS[v].pend > 3'd1 ? int'(VECS[v].pend) : 0);
        chk($sformatf("R1 take_level vec%0d", v), int'(take_level), int'(VECS[v].pend));
      end
      @(negedge clk); irq = '0;
      @(negedge clk);
    end

    // R3 R4 R6: non-maskable against full masking
    en = '0; ps_il = 3'd7; ps_excm = 1'b1;
    @(negedge clk); irq[30] = 1'b1;
    @(negedge clk); #1;
    chk("R3 nmi pend_level", int'(pend_level), 7);
    chk("R3 nmi take", int'(take), 1);
    chk("R6 nmi vec_idx", int'(vec_idx), 7);
    @(negedge clk); #1;
    chk("R4 nmi auto clear", int'(pend_level), 0);
    chk("R5 no take after take", int'(take), 0);
    chk("R6 stat_upd", int'(stat_upd), 1);
    chk("R6 stat_intlevel", int'(stat_il), 7);
    chk("R6 stat_excm", int'(stat_excm), 1);
    @(negedge clk); #1;
    chk("R4 held high stays clear", int'(pend_level), 0);
    irq[30] = 1'b0;

    // R9 edge kind, line 24 at level 2
    en = '1; ps_il = 3'd6; ps_excm = 1'b0;
    @(negedge clk); irq[24] = 1'b1;
    @(negedge clk); #1;
    chk("R9 edge latched", int'(pend_level), 2);
    irq[24] = 1'b0;
    @(negedge clk); #1;
    chk("R9 edge held", int'(pend_level), 2);
    @(negedge clk);
    irq[24] = 1'b1; sw_clr = 1'b1; sw_data = '0; sw_data[24] = 1'b1;
    @(negedge clk);
    sw_clr = 1'b0; sw_data = '0; #1;
    chk("R9 edge wins over clear", int'(pend_level), 2);
    sw_write(1'b0, 1'b1, 24);
    chk("R9 clear edge line", int'(pend_level), 0);
    irq[24] = 1'b0;

    // R10 software kind
    sw_write(1'b1, 1'b0, 29);
    chk("R10 soft set", int'(pend_level), 3);
    sw_write(1'b0, 1'b1, 29);
    chk("R10 soft clear", int'(pend_level), 0);
    sw_write(1'b1, 1'b0, 24);
    chk("R10 set ignored on edge line", int'(pend_level), 0);

    // R8 level kind ignores clear
    @(negedge clk); irq[0] = 1'b1; #1;
    chk("R8 level follows input", int'(pend_level), 1);
    sw_write(1'b0, 1'b1, 0);
    chk("R8 clear ignored on level line", int'(pend_level), 1);
    irq[0] = 1'b0; #1;
    chk("R8 level drops with input", int'(pend_level), 0);

    // R7 R5 level-1 take
    @(negedge clk); ps_il = 3'd0; irq[0] = 1'b1; #1;
    chk("R7 level1 take", int'(take), 1);
    chk("R7 level1 vec_idx", int'(vec_idx), 0);
    @(negedge clk); #1;
    chk("R5 strobe one cycle", int'(take), 0);
    chk("R7 cause_vld", int'(cause_vld), 1);
    chk("R7 cause code", int'(cause), 4);
    chk("R7 stat_excm", int'(stat_excm), 1);
    chk("R7 stat_intlevel kept", int'(stat_il), 0);
    @(negedge clk); #1;
    chk("R5 take again after gap", int'(take), 1);
    irq[0] = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule